// File: doc/BRIEF.md
# PHY Pad-Calibration and DLL Bring-Up Sequencer

This block brings the analog side of a storage-interface PHY out of power-down without software polling. A power-on request writes the pad settings first: drive type, output tap-delay enable and output tap-delay select. It then holds the calibration power-down-bar low long enough for the calibration state flops to initialise. Next it releases the bar and waits for the calibration-done status. It then derives a DLL frequency code from the card clock rate, drives that code, enables the DLL and waits for DLL-ready. Each wait is bounded by its own timeout. The sequencer reports completion, an error flag and a code that names the step that failed.

A power-off request only drops the power-down-bar and completes at once. The analog pads and the DLL are outside the block. Their status bits arrive asynchronously, and each one passes through a two-flop synchroniser. All delays are given in nanoseconds together with the system clock frequency, and they are turned into cycle counts at elaboration.

There is no data stream through the block. Every pin is plain control or status, and requests are single-cycle strobes that are accepted only while the sequencer is idle.

Top module: `phy_bringup_seq`

## Requirements
- R1: After reset, every output is 0: power-down-bar, DLL enable, frequency code, drive type, tap-delay enable, tap-delay select, busy, done, error, error code and rate warning.
- R2: When a power-on request is accepted, the power-down-bar goes low on that clock edge and stays low for exactly SETTLE cycles (SETTLE = ceil(SYS_CLK_KHZ*SETTLE_NS/1e6)). It then goes high.
- R3: On the edge that accepts a power-on request, drive type becomes 6, tap-delay enable becomes 0 and tap-delay select becomes 4. Busy is 1 from that edge until the sequence ends.
- R4: If synchronised calibration-done is not seen within CAL_TMO cycles after the power-down-bar rises, the sequence ends with done=1, error=1 and error code 1. The DLL enable stays 0.
- R5: The frequency code is round(rate_khz/50000) clamped to 3. The codes are 0 for rate < 25000, 1 for 25000..74999, 2 for 75000..124999 and 3 for 125000 and above.
- R6: The rate warning is 1 exactly when the rounded quotient exceeds 3, i.e. rate_khz >= 175000. It is latched at request time, and the sequence still proceeds with code 3.
- R7: The frequency code is driven at least one cycle before DLL enable rises. It does not change while DLL enable rises, and DLL enable rises only while the power-down-bar is high.
- R8: If synchronised DLL-ready is not seen within DLL_TMO cycles after DLL enable rises, the sequence ends with done=1, error=1 and error code 2.
- R9: A successful sequence ends with done=1, error=0, error code 0, the power-down-bar high and DLL enable high.
- R10: An accepted power-off request drives the power-down-bar low. On the next edge done=1, error=0 and error code 0, and busy stays 0.
- R11: Requests that arrive while busy are ignored. If power-on and power-off arrive together while idle, power-off wins.
- R12: Done, error and error code hold their values until the next accepted request, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_on_req | input | 1 | Power-on request strobe |
| pwr_off_req | input | 1 | Power-off request strobe |
| card_rate_khz | input | RATE_W | Card clock rate in kHz, sampled with the request |
| cal_done_async | input | 1 | Pad calibration done status (asynchronous) |
| dll_ready_async | input | 1 | DLL ready status (asynchronous) |
| cal_pdb_o | output | 1 | Calibration power-down-bar |
| dll_en_o | output | 1 | DLL enable |
| dll_freq_o | output | 3 | DLL frequency code |
| pad_drive_o | output | 3 | Pad drive type field |
| otap_en_o | output | 1 | Output tap-delay enable |
| otap_sel_o | output | 4 | Output tap-delay select |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last request finished |
| err_o | output | 1 | Last request failed |
| err_code_o | output | 2 | Failing step: 0 none, 1 calibration timeout, 2 DLL timeout |
| rate_warn_o | output | 1 | Unsupported card rate, code clamped |

## Verification
The bench builds the block with a 125 MHz system clock and shrinks the delays to 80 ns, 480 ns and 960 ns. That gives a 10-cycle settle, a 60-cycle calibration timeout and a 120-cycle DLL timeout. With these values both timeout paths, as well as success after long but in-window latencies, fit into a few hundred cycles per sequence, so many random sequences can run. The default 50 ms DLL timeout stays exercised only through elaboration of its counter width.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETTLE = 3'd1,
    ST_CAL    = 3'd2,
    ST_FREQ   = 3'd3,
    ST_DLL    = 3'd4
  } seq_state_t;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_CAL  = 2'd1,
    ERR_DLL  = 2'd2
  } seq_err_t;

  localparam logic [2:0] PAD_DRIVE_50OHM = 3'd6;
  localparam logic [3:0] OTAP_SEL_INIT   = 4'd4;

  // ceil(khz * ns / 1e6), never below one cycle
  function automatic int unsigned ns_to_cycles(input int unsigned khz,
                                               input int unsigned ns);
    longint unsigned prod;
    longint unsigned cyc;
    prod = longint'(khz) * longint'(ns);
    cyc  = (prod + 64'd999999) / 64'd1000000;
    if (cyc == 0) cyc = 1;
    return int'(cyc);
  endfunction

endpackage

// File: rtl/status_sync.sv
module status_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= async_i[b];
        sync_q <= meta_q;
      end
    end
    assign sync_o[b] = sync_q;
  end
endmodule

// File: rtl/rate_coder.sv
module rate_coder #(
  parameter int RATE_W   = 20,
  parameter int STEP_KHZ = 50000,
  parameter int MAX_CODE = 3
) (
  input  logic [RATE_W-1:0] rate_khz,
  output logic [2:0]        code_o,
  output logic              warn_o
);
  // quotient rounded to nearest is >= k once rate >= k*STEP - STEP/2
  logic [MAX_CODE:0] at_least;

  for (genvar k = 1; k <= MAX_CODE + 1; k++) begin : g_thr
    localparam longint THR = longint'(k) * STEP_KHZ - STEP_KHZ / 2;
    assign at_least[k-1] = (longint'(rate_khz) >= THR);
  end

  always_comb begin
    code_o = 3'd0;
    for (int k = 0; k < MAX_CODE; k++) begin
      if (at_least[k]) code_o = 3'(k + 1);
    end
    warn_o = at_least[MAX_CODE];
  end
endmodule

// File: rtl/step_timer.sv
module step_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (!last_o) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == limit - 1'b1);
endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
  import phy_seq_pkg::*;
#(
  parameter int unsigned SYS_CLK_KHZ = 125000,
  parameter int unsigned SETTLE_NS   = 5000,
  parameter int unsigned CAL_TMO_NS  = 50000,
  parameter int unsigned DLL_TMO_NS  = 50000000,
  parameter int          RATE_W      = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_on_req,
  input  logic              pwr_off_req,
  input  logic [RATE_W-1:0] card_rate_khz,
  input  logic              cal_done_async,
  input  logic              dll_ready_async,
  output logic              cal_pdb_o,
  output logic              dll_en_o,
  output logic [2:0]        dll_freq_o,
  output logic [2:0]        pad_drive_o,
  output logic              otap_en_o,
  output logic [3:0]        otap_sel_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [1:0]        err_code_o,
  output logic              rate_warn_o
);
  localparam int unsigned SETTLE_CYC = ns_to_cycles(SYS_CLK_KHZ, SETTLE_NS);
  localparam int unsigned CAL_CYC    = ns_to_cycles(SYS_CLK_KHZ, CAL_TMO_NS);
  localparam int unsigned DLL_CYC    = ns_to_cycles(SYS_CLK_KHZ, DLL_TMO_NS);
  localparam int unsigned MAX_CYC    =
    (DLL_CYC > CAL_CYC) ? ((DLL_CYC > SETTLE_CYC) ? DLL_CYC : SETTLE_CYC)
                        : ((CAL_CYC > SETTLE_CYC) ? CAL_CYC : SETTLE_CYC);
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  seq_state_t       state_q;
  logic [1:0]       stat_sync;
  logic             cal_ok, dll_ok;
  logic [2:0]       code_now;
  logic             warn_now;
  logic [2:0]       code_q;
  logic             tmr_clr, tmr_last;
  logic [CNT_W-1:0] tmr_limit;

  status_sync #(.W(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({dll_ready_async, cal_done_async}),
    .sync_o  (stat_sync)
  );
  assign cal_ok = stat_sync[0];
  assign dll_ok = stat_sync[1];

  rate_coder #(.RATE_W(RATE_W)) u_coder (
    .rate_khz (card_rate_khz),
    .code_o   (code_now),
    .warn_o   (warn_now)
  );

  always_comb begin
    unique case (state_q)
      ST_SETTLE: tmr_limit = CNT_W'(SETTLE_CYC);
      ST_CAL:    tmr_limit = CNT_W'(CAL_CYC);
      ST_DLL:    tmr_limit = CNT_W'(DLL_CYC);
      default:   tmr_limit = CNT_W'(MAX_CYC);
    endcase
  end

  // restart the window on every state change
  always_comb begin
    tmr_clr = 1'b1;
    unique case (state_q)
      ST_SETTLE: tmr_clr = tmr_last;
      ST_CAL:    tmr_clr = cal_ok;
      ST_DLL:    tmr_clr = 1'b0;
      default:   tmr_clr = 1'b1;
    endcase
  end

  step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (tmr_clr),
    .limit  (tmr_limit),
    .last_o (tmr_last)
  );

  assign busy_o = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cal_pdb_o   <= 1'b0;
      dll_en_o    <= 1'b0;
      dll_freq_o  <= 3'd0;
      pad_drive_o <= 3'd0;
      otap_en_o   <= 1'b0;
      otap_sel_o  <= 4'd0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
      err_code_o  <= ERR_NONE;
      rate_warn_o <= 1'b0;
      code_q      <= 3'd0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (pwr_off_req) begin
            cal_pdb_o  <= 1'b0;
            done_o     <= 1'b1;
            err_o      <= 1'b0;
            err_code_o <= ERR_NONE;
          end else if (pwr_on_req) begin
            cal_pdb_o   <= 1'b0;
            dll_en_o    <= 1'b0;
            pad_drive_o <= PAD_DRIVE_50OHM;
            otap_en_o   <= 1'b0;
            otap_sel_o  <= OTAP_SEL_INIT;
            done_o      <= 1'b0;
            err_o       <= 1'b0;
            err_code_o  <= ERR_NONE;
            code_q      <= code_now;
            rate_warn_o <= warn_now;
            state_q     <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (tmr_last) begin
            cal_pdb_o <= 1'b1;
            state_q   <= ST_CAL;
          end
        end
        ST_CAL: begin
          if (cal_ok) begin
            dll_freq_o <= code_q;
            state_q    <= ST_FREQ;
          end else if (tmr_last) begin
            done_o     <= 1'b1;
            err_o      <= 1'b1;
            err_code_o <= ERR_CAL;
            state_q    <= ST_IDLE;
          end
        end
        ST_FREQ: begin
          dll_en_o <= 1'b1;
          state_q  <= ST_DLL;
        end
        ST_DLL: begin
          if (dll_ok) begin
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (tmr_last) begin
            done_o     <= 1'b1;
            err_o      <= 1'b1;
            err_code_o <= ERR_DLL;
            state_q    <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phy_bringup_seq_chk.sv
module phy_bringup_seq_chk #(
  parameter int unsigned SETTLE_CYC = 10,
  parameter int unsigned CAL_CYC    = 60
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_on_req,
  input logic       pwr_off_req,
  input logic       cal_pdb_o,
  input logic       dll_en_o,
  input logic [2:0] dll_freq_o,
  input logic [2:0] pad_drive_o,
  input logic       otap_en_o,
  input logic [3:0] otap_sel_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o,
  input logic [1:0] err_code_o
);
  logic [31:0] low_cnt, cal_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      cal_cnt <= '0;
    end else begin
      if (!busy_o)         low_cnt <= '0;
      else if (!cal_pdb_o) low_cnt <= low_cnt + 1;
      if (!busy_o || !cal_pdb_o || dll_en_o) cal_cnt <= '0;
      else if (cal_cnt != 32'hFFFF_FFFF)     cal_cnt <= cal_cnt + 1;
    end
  end

  p_settle_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_pdb_o) |-> (low_cnt == SETTLE_CYC));

  p_pad_fields_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (pad_drive_o == 3'd6 && !otap_en_o && otap_sel_o == 4'd4 && !cal_pdb_o));

  p_cal_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cal_cnt <= CAL_CYC + 1);

  p_cal_err_no_dll_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && err_code_o == 2'd1) |-> !dll_en_o);

  p_freq_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dll_freq_o <= 3'd3);

  p_freq_before_dll_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dll_en_o) |-> (cal_pdb_o && $stable(dll_freq_o)));

  p_err_has_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (done_o && err_code_o != 2'd0));

  p_off_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && pwr_off_req) |=> (!cal_pdb_o && done_o && !err_o && !busy_o));

  p_busy_ignores_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && (pwr_on_req || pwr_off_req)) |=> $stable(pad_drive_o));
endmodule

bind phy_bringup_seq phy_bringup_seq_chk #(
  .SETTLE_CYC (SETTLE_CYC),
  .CAL_CYC    (CAL_CYC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pwr_on_req  (pwr_on_req),
  .pwr_off_req (pwr_off_req),
  .cal_pdb_o   (cal_pdb_o),
  .dll_en_o    (dll_en_o),
  .dll_freq_o  (dll_freq_o),
  .pad_drive_o (pad_drive_o),
  .otap_en_o   (otap_en_o),
  .otap_sel_o  (otap_sel_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .err_code_o  (err_code_o)
);

// File: tb/phy_bringup_seq_bench.sv
module phy_bringup_seq_bench;
  localparam int SETTLE = 10;
  localparam int CALT   = 60;
  localparam int DLLT   = 120;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_on_req = 1'b0, pwr_off_req = 1'b0;
  logic [19:0] card_rate_khz = '0;
  logic        cal_done_async = 1'b0, dll_ready_async = 1'b0;
  logic        cal_pdb_o, dll_en_o, otap_en_o, busy_o, done_o, err_o, rate_warn_o;
  logic [2:0]  dll_freq_o, pad_drive_o;
  logic [3:0]  otap_sel_o;
  logic [1:0]  err_code_o;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  phy_bringup_seq #(
    .SYS_CLK_KHZ(125000), .SETTLE_NS(80), .CAL_TMO_NS(480), .DLL_TMO_NS(960), .RATE_W(20)
  ) u_phy_bringup_seq (
    .clk(clk), .rst_n(rst_n), .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req),
    .card_rate_khz(card_rate_khz), .cal_done_async(cal_done_async),
    .dll_ready_async(dll_ready_async), .cal_pdb_o(cal_pdb_o), .dll_en_o(dll_en_o),
    .dll_freq_o(dll_freq_o), .pad_drive_o(pad_drive_o), .otap_en_o(otap_en_o),
    .otap_sel_o(otap_sel_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .err_code_o(err_code_o), .rate_warn_o(rate_warn_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_code(input int rate);
    int q = (rate + 25000) / 50000;
    return (q > 3) ? 3 : q;
  endfunction

  function automatic bit exp_warn(input int rate);
    return ((rate + 25000) / 50000) > 3;
  endfunction

  // cal_lat/dll_lat < 0: status never arrives; poke: pulse requests mid-run
  task automatic run_on(input int rate, input int cal_lat, input int dll_lat, input bit poke);
    int lows = 0, his = 0, dlls = 0, n = 0;
    bit seen_hi = 0;
    @(negedge clk);
    card_rate_khz = 20'(rate);
    pwr_on_req = 1'b1;
    @(negedge clk);
    pwr_on_req = 1'b0;
    chk(busy_o && pad_drive_o == 3'd6, "R3 drive", pad_drive_o, 6);
    chk(!otap_en_o && otap_sel_o == 4'd4, "R3 tap", otap_sel_o, 4);
    while (busy_o && n < 2000) begin
      n++;
      if (!cal_pdb_o && !seen_hi) lows++;
      if (cal_pdb_o) seen_hi = 1;
      if (cal_pdb_o) his++;
      if (dll_en_o) dlls++;
      cal_done_async  = cal_pdb_o && cal_lat >= 0 && his > cal_lat;
      dll_ready_async = dll_en_o && dll_lat >= 0 && dlls > dll_lat;
      if (poke && n == 5) begin pwr_off_req = 1'b1; pwr_on_req = 1'b1; end
      else begin pwr_off_req = 1'b0; pwr_on_req = 1'b0; end
      @(negedge clk);
    end
    pwr_off_req = 1'b0; pwr_on_req = 1'b0;
    chk(lows == SETTLE, "R2 settle", lows, SETTLE);
    chk(rate_warn_o == exp_warn(rate), "R6 warn", rate_warn_o, int'(exp_warn(rate)));
    if (cal_lat < 0) begin
      chk(done_o && err_o && err_code_o == 2'd1 && !dll_en_o, "R4 cal timeout", err_code_o, 1);
    end else begin
      chk(dll_freq_o == 3'(exp_code(rate)), "R5 code", dll_freq_o, exp_code(rate));
      if (dll_lat < 0)
        chk(done_o && err_o && err_code_o == 2'd2, "R8 dll timeout", err_code_o, 2);
      else begin
        chk(done_o && !err_o && err_code_o == 2'd0 && dll_en_o, "R9 success", err_code_o, 0);
        if (poke) chk(cal_pdb_o, "R11 busy ignore", cal_pdb_o, 1);
        else chk(cal_pdb_o && dll_en_o, "R7 dll on after freq", dll_en_o, 1);
      end
    end
    repeat (3) @(negedge clk);
    chk(done_o && err_code_o == (cal_lat < 0 ? 2'd1 : dll_lat < 0 ? 2'd2 : 2'd0),
        "R12 hold", err_code_o, cal_lat < 0 ? 1 : dll_lat < 0 ? 2 : 0);
    cal_done_async = 1'b0;
    dll_ready_async = 1'b0;
  endtask

  task automatic run_off(input bit both);
    @(negedge clk);
    pwr_off_req = 1'b1;
    pwr_on_req = both;
    @(negedge clk);
    pwr_off_req = 1'b0;
    pwr_on_req = 1'b0;
    chk(!cal_pdb_o && done_o && !err_o && err_code_o == 2'd0, "R10 power off", cal_pdb_o, 0);
    chk(!busy_o, both ? "R11 off wins" : "R10 not busy", busy_o, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!cal_pdb_o && !dll_en_o && dll_freq_o == 0 && pad_drive_o == 0 && !otap_en_o &&
        otap_sel_o == 0 && !busy_o && !done_o && !err_o && err_code_o == 0 && !rate_warn_o,
        "R1 reset", {cal_pdb_o, dll_en_o, busy_o, done_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // directed rate boundaries
    run_on(0, 3, 5, 0);
    run_on(24999, 3, 5, 0);
    run_on(25000, 3, 5, 0);
    run_on(74999, 3, 5, 0);
    run_on(75000, 3, 5, 0);
    run_on(124999, 3, 5, 0);
    run_on(125000, 3, 5, 0);
    run_on(174999, 3, 5, 0);
    run_on(175000, 3, 5, 0);
    run_on(1048575, 3, 5, 0);
    // timeouts and near-limit latencies
    run_on(50000, -1, 5, 0);
    run_on(100000, 0, -1, 0);
    run_on(100000, CALT - 8, DLLT - 8, 0);
    run_off(0);
    run_on(150000, 10, 20, 1);
    run_off(1);
    for (int i = 0; i < 25; i++) begin
      int rate = int'($urandom % 260000);
      int cl = ($urandom % 6 == 0) ? -1 : int'($urandom % (CALT - 8));
      int dl = ($urandom % 6 == 0) ? -1 : int'($urandom % (DLLT - 8));
      run_on(rate, cl, dl, ($urandom % 4) == 0);
      if ($urandom % 5 == 0) run_off(0);
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule